// File: doc/BRIEF.md
# ATA PIO and Nondata Command Sequencer

This block is the device-side protocol engine of a disk interface. It steps the busy flag, the data-request flag and the pending-interrupt flag through the phases of a command. When a command starts it receives a one-cycle start pulse, a command class and a sector count. It then asks a back-end stub to prepare or process each block through a request/done handshake. For every block it counts the host's word strobes on the data port before it leaves the data phase.

Reads, writes and nondata commands follow different flag orderings. A read raises the interrupt together with every data request. A write requests its first block silently. After each written block it interrupts once the back end has finished processing that block. Multiple mode groups sectors into blocks of a programmed size. An error from the back end ends the command early.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, busy, data request, interrupt, error and back-end request are all 0.
- R2: A start pulse while idle sets busy and the back-end request, and clears data request, interrupt and error on the next cycle.
- R3: A nondata command (class code 0, or the unused code 3) ends on back-end done with busy 0, data request 0, interrupt 1, and error equal to the back end's error flag. A status read clears a pending interrupt on the next cycle, unless back-end done arrives in that same cycle.
- R4: A read (class code 1) leaves preparation on back-end done with busy 0, data request 1 and interrupt 1.
- R5: A block is the block's sector count times WORDS_PER_SECTOR word strobes. Data request drops in the cycle after the last strobe. Strobes while data request is low have no effect.
- R6: After a read block, busy and the back-end request rise again if sectors remain. Otherwise the sequencer returns to idle with no new interrupt.
- R7: A write (class code 2) raises data request for its first block with busy 0 and no interrupt.
- R8: After a written block, busy rises with data request 0. On back-end done, busy clears and the interrupt is set, and data request rises again if sectors remain.
- R9: A sector count of 0 transfers 256 sectors.
- R10: Outside multiple mode a block is one sector. In multiple mode it is the smaller of the programmed block size (0 taken as 1) and the remaining sectors. The sector count of the current block is shown to the back end, and there is one interrupt per block.
- R11: A write-processing error ends the command with busy 0, data request 0, interrupt 1 and error 1, and no further block is requested. A read-preparation error still presents that block, with error 1, and then ends the command.
- R12: A start pulse while the sequencer is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Command start pulse |
| cmd_class_i | input | 2 | 0 nondata, 1 read, 2 write |
| sec_count_i | input | CNT_W | Sector count, 0 means 256 |
| multi_i | input | 1 | Multiple mode enable |
| blk_size_i | input | CNT_W | Sectors per block in multiple mode |
| status_rd_i | input | 1 | Host status read |
| word_strobe_i | input | 1 | One data word transferred |
| be_done_i | input | 1 | Back end finished preparing or processing |
| be_err_i | input | 1 | Error flag qualified by be_done_i |
| be_req_o | output | 1 | Back-end work request |
| be_nsec_o | output | CNT_W+1 | Sectors in current block |
| bsy_o | output | 1 | Busy flag |
| drq_o | output | 1 | Data request flag |
| irq_o | output | 1 | Interrupt pending |
| err_o | output | 1 | Error flag of current command |

## Verification
The bench runs several configurations: sector counts of 1, 3, 5 and 7, a count of 0, and multiple-mode block sizes of 0, 2, 4, 8 and 16. It predicts each block size arithmetically. A design that ignores the 0-means-256 rule would end the command after no sectors or after the wrong number. A sizer that mishandles the short last block or a block size of 0 would drop data request at the wrong strobe.

Writes are checked for a silent first request. A design that reuses the read ordering would show an interrupt too early. Errors are injected on a middle write block and on the first read block, where a wrong design would go on to request another block. Stray strobes during busy, and a second start pulse during a transfer, must leave the sequence unchanged.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  typedef enum logic [1:0] {
    CLS_NONDATA = 2'd0,
    CLS_READ    = 2'd1,
    CLS_WRITE   = 2'd2
  } cmd_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_XFER = 2'd2,
    ST_PROC = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ata_blk_sizer.sv
module ata_blk_sizer #(
  parameter int CNT_W = 8,
  localparam int REM_W = CNT_W + 1
) (
  input  logic             multi_i,
  input  logic [CNT_W-1:0] blk_i,
  input  logic [REM_W-1:0] rem_i,
  output logic [REM_W-1:0] nsec_o
);
  logic [REM_W-1:0] bs;

  always_comb begin
    bs = (blk_i == '0) ? REM_W'(1) : {1'b0, blk_i};
    if (!multi_i)       nsec_o = REM_W'(1);
    else if (bs < rem_i) nsec_o = bs;
    else                nsec_o = rem_i;
  end
endmodule

// File: rtl/ata_word_ctr.sv
module ata_word_ctr #(
  parameter int CW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          end_o
);
  logic [CW-1:0] cnt_q;

  assign end_o = dec_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CW'(1);
  end

  // R5: a counted strobe never finds the counter empty
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_seq_pkg::*;
#(
  parameter int CNT_W            = 8,
  parameter int WORDS_PER_SECTOR = 256,
  localparam int REM_W = CNT_W + 1,
  localparam int CW    = REM_W + $clog2(WORDS_PER_SECTOR) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_start_i,
  input  logic [1:0]       cmd_class_i,
  input  logic [CNT_W-1:0] sec_count_i,
  input  logic             multi_i,
  input  logic [CNT_W-1:0] blk_size_i,
  input  logic             status_rd_i,
  input  logic             word_strobe_i,
  input  logic             be_done_i,
  input  logic             be_err_i,
  output logic             be_req_o,
  output logic [REM_W-1:0] be_nsec_o,
  output logic             bsy_o,
  output logic             drq_o,
  output logic             irq_o,
  output logic             err_o
);
  seq_st_e          st_q;
  cmd_cls_e         cls_q;
  logic [REM_W-1:0] rem_q, nsec_q, sz_rem, sz_nsec, ext_rem;
  logic             multi_q, sz_multi;
  logic [CNT_W-1:0] blk_q, sz_blk;
  logic             idle, take_blk, blk_end, ctr_load, irq_set;
  logic [REM_W-1:0] ld_nsec;

  assign idle     = (st_q == ST_IDLE);
  assign bsy_o    = (st_q == ST_PREP) || (st_q == ST_PROC);
  assign drq_o    = (st_q == ST_XFER);
  assign be_req_o = bsy_o;
  assign be_nsec_o = nsec_q;

  always_comb begin
    ext_rem  = (sec_count_i == '0) ? (REM_W'(1) << CNT_W) : {1'b0, sec_count_i};
    sz_rem   = idle ? ext_rem : rem_q;
    sz_multi = idle ? multi_i : multi_q;
    sz_blk   = idle ? blk_size_i : blk_q;
  end

  ata_blk_sizer #(.CNT_W(CNT_W)) u_sizer (
    .multi_i(sz_multi), .blk_i(sz_blk), .rem_i(sz_rem), .nsec_o(sz_nsec)
  );

  // a new block is taken at command start, after a read block, or after write processing
  always_comb begin
    take_blk = (idle && cmd_start_i)
            || (st_q == ST_XFER && blk_end && cls_q == CLS_READ && !err_o && rem_q != '0)
            || (st_q == ST_PROC && be_done_i && !be_err_i && rem_q != '0);
    ctr_load = (st_q == ST_PREP && be_done_i && cls_q != CLS_NONDATA)
            || (st_q == ST_PROC && be_done_i && !be_err_i && rem_q != '0);
    ld_nsec  = (st_q == ST_PROC) ? sz_nsec : nsec_q;
    irq_set  = be_done_i && ((st_q == ST_PROC)
            || (st_q == ST_PREP && cls_q != CLS_WRITE));
  end

  ata_word_ctr #(.CW(CW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(ctr_load),
    .load_val_i(CW'(ld_nsec) * CW'(WORDS_PER_SECTOR)),
    .dec_i(word_strobe_i && drq_o),
    .end_o(blk_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cls_q <= CLS_NONDATA;
      rem_q <= '0; nsec_q <= '0; multi_q <= 1'b0; blk_q <= '0;
      irq_o <= 1'b0; err_o <= 1'b0;
    end else begin
      if (take_blk) begin
        nsec_q <= sz_nsec;
        rem_q  <= sz_rem - sz_nsec;
      end
      if (irq_set)          irq_o <= 1'b1;
      else if (status_rd_i) irq_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_start_i) begin
          st_q    <= ST_PREP;
          cls_q   <= (cmd_class_i == 2'd1) ? CLS_READ :
                     (cmd_class_i == 2'd2) ? CLS_WRITE : CLS_NONDATA;
          multi_q <= multi_i;
          blk_q   <= blk_size_i;
          irq_o   <= 1'b0;
          err_o   <= 1'b0;
        end
        ST_PREP: if (be_done_i) begin
          if (cls_q == CLS_NONDATA) begin
            st_q  <= ST_IDLE;
            err_o <= be_err_i;
          end else begin
            st_q <= ST_XFER;
            if (cls_q == CLS_READ) err_o <= be_err_i;
          end
        end
        ST_XFER: if (blk_end) begin
          if (cls_q == CLS_WRITE)               st_q <= ST_PROC;
          else if (!err_o && rem_q != '0)       st_q <= ST_PREP;
          else                                  st_q <= ST_IDLE;
        end
        ST_PROC: if (be_done_i) begin
          if (be_err_i) begin
            st_q  <= ST_IDLE;
            err_o <= 1'b1;
          end else if (rem_q != '0) st_q <= ST_XFER;
          else                      st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start makes the device busy with no stale interrupt
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && !bsy_o && !drq_o) |=> (bsy_o && !irq_o && !err_o));

  // R3: status read without a completing event clears the interrupt
  p_irq_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !be_done_i && !(cmd_start_i && idle)) |=> !irq_o);

  // R7: the first write data request comes without an interrupt
  p_write_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PREP && be_done_i && cls_q == CLS_WRITE) |=> (drq_o && !irq_o));

  // R11: write processing error ends the command
  p_err_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROC && be_done_i && be_err_i) |=> (!bsy_o && !drq_o && irq_o && err_o));

  // R12: a start while active leaves the phase unchanged
  p_ignore_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && drq_o && !word_strobe_i) |=> drq_o);
endmodule

// File: tb/ata_pio_seq_test.sv
module ata_pio_seq_test;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 0, multi = 0, status_rd = 0, word = 0, be_done = 0, be_err = 0;
  logic [1:0] cmd_class = 0;
  logic [7:0] sec_count = 0, blk_size = 0;
  logic       be_req, bsy, drq, irq, err;
  logic [8:0] be_nsec;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  ata_pio_seq #(.CNT_W(8), .WORDS_PER_SECTOR(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .cmd_class_i(cmd_class),
    .sec_count_i(sec_count), .multi_i(multi), .blk_size_i(blk_size),
    .status_rd_i(status_rd), .word_strobe_i(word), .be_done_i(be_done),
    .be_err_i(be_err), .be_req_o(be_req), .be_nsec_o(be_nsec), .bsy_o(bsy),
    .drq_o(drq), .irq_o(irq), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input int cls, input int cnt, input bit m, input int bsz);
    cmd_class = 2'(cls); sec_count = 8'(cnt); multi = m; blk_size = 8'(bsz);
    cmd_start = 1; step(); cmd_start = 0;
    chk("R2 bsy", bsy, 1); chk("R2 drq", drq, 0);
    chk("R2 irq", irq, 0); chk("R2 req", be_req, 1); chk("R2 err", err, 0);
  endtask

  task automatic done(input bit e);
    be_done = 1; be_err = e; step(); be_done = 0; be_err = 0;
  endtask

  task automatic srd();
    status_rd = 1; step(); status_rd = 0;
    chk("R3 irq cleared", irq, 0);
  endtask

  task automatic strobes(input int n);
    word = 1;
    for (int i = 0; i < n - 1; i++) step();
    chk("R5 drq before last word", drq, 1);
    step(); word = 0;
    chk("R5 drq after last word", drq, 0);
  endtask

  function automatic int bsize(input int rem, input bit m, input int bsz);
    int b = (bsz == 0) ? 1 : bsz;
    if (!m) return 1;
    return (b < rem) ? b : rem;
  endfunction

  task automatic run_read(input int cnt, input bit m, input int bsz, input int err_blk, input bit poke);
    int rem = (cnt == 0) ? 256 : cnt;
    int total = 0, blk = 0, exp_total = (err_blk >= 0) ? 0 : rem;
    issue(1, cnt, m, bsz);
    forever begin
      int nsec = bsize(rem, m, bsz);
      bit e = (blk == err_blk);
      bit more;
      chk("R10 block sectors", be_nsec, nsec);
      word = 1; step(); word = 0;
      step();
      done(e);
      chk("R4 bsy", bsy, 0); chk("R4 drq", drq, 1); chk("R4 irq", irq, 1);
      chk("R11 read err flag", err, e);
      if (poke) begin
        cmd_class = 2; cmd_start = 1; step(); cmd_start = 0;
        chk("R12 drq kept", drq, 1); chk("R12 bsy kept", bsy, 0);
      end
      srd();
      strobes(nsec * W);
      rem -= nsec; total += nsec;
      more = (rem > 0) && !e;
      chk("R6 bsy", bsy, more); chk("R6 req", be_req, more); chk("R6 irq", irq, 0);
      if (!more) break;
      blk++;
    end
    if (err_blk < 0) chk("R9 sectors read", total, exp_total);
    else chk("R11 read stops after error block", blk, err_blk);
  endtask

  task automatic run_write(input int cnt, input bit m, input int bsz, input int err_blk);
    int rem = (cnt == 0) ? 256 : cnt;
    int blk = 0;
    int nsec = bsize(rem, m, bsz);
    issue(2, cnt, m, bsz);
    chk("R10 block sectors", be_nsec, nsec);
    step();
    done(0);
    chk("R7 drq", drq, 1); chk("R7 bsy", bsy, 0); chk("R7 irq", irq, 0);
    forever begin
      bit e = (blk == err_blk);
      bit more;
      strobes(nsec * W);
      chk("R8 bsy after block", bsy, 1); chk("R8 req", be_req, 1);
      rem -= nsec;
      step();
      done(e);
      more = (rem > 0) && !e;
      chk("R8 bsy done", bsy, 0); chk("R8 irq", irq, 1);
      chk("R8 drq next block", drq, more);
      if (e) chk("R11 write err", err, 1);
      srd();
      if (!more) break;
      blk++;
      nsec = bsize(rem, m, bsz);
      chk("R10 block sectors", be_nsec, nsec);
    end
    chk("R11 idle after write", bsy | drq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 bsy", bsy, 0); chk("R1 drq", drq, 0); chk("R1 irq", irq, 0);
    chk("R1 err", err, 0); chk("R1 req", be_req, 0);
    rst_n = 1; step();

    // R3 nondata, with and without error, and class code 3
    issue(0, 1, 0, 0); step(); done(0);
    chk("R3 bsy", bsy, 0); chk("R3 drq", drq, 0); chk("R3 irq", irq, 1); chk("R3 err", err, 0);
    srd();
    issue(3, 1, 0, 0); done(1);
    chk("R3 code3 drq", drq, 0); chk("R3 err", err, 1); chk("R3 irq", irq, 1);
    srd();

    run_read(1, 0, 0, -1, 0);
    run_read(3, 0, 0, -1, 1);       // R12 poke
    run_read(0, 0, 0, -1, 0);       // R9
    run_read(5, 1, 2, -1, 0);       // R10 2,2,1
    run_read(3, 1, 0, -1, 0);       // R10 block size 0
    run_read(3, 1, 8, -1, 0);       // R10 block larger than count
    run_read(0, 1, 16, -1, 0);      // R9 and R10
    run_read(3, 0, 0, 0, 0);        // R11 read error

    run_write(2, 0, 0, -1);
    run_write(7, 1, 4, -1);
    run_write(0, 1, 8, -1);         // R9
    run_write(4, 0, 0, 1);          // R11 write error on second block

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule